// File: doc/BRIEF.md
# Extended Bank Controller for an 8-bit Memory Map

This block sits beside the CPU of an 8-bit home computer and turns one 8-bit control register into memory-map decisions. The register sits at the peripheral address `$D301` and software writes it to switch the operating-system ROM, the BASIC ROM and the self-test ROM in and out. Two more fields steer which bank of extra RAM appears in the 16 KB window at `$4000-$7FFF`. All RAM, both the base 64 KB and the extra banks, lives in two 1 MB SRAM chips, which gives 128 banks of 16 KB.

The register runs in one of two modes, chosen by bit 6. When bit 6 is 1 (compatible mode), the register follows the classic four-bank expanded-memory rules. When bit 6 is 0 (extended mode), the remaining seven bits form a bank number that reaches any of the 128 banks. During extended mode the three ROM-control functions keep the values they had when the mode was entered.

The block drives the SRAM address bits above A13 and a pair of chip-enable lines that are cross-wired between the two chips. Each line is the active-low enable of one chip and the active-high enable of the other. The active-high enable is qualified by the phase-2 clock, so a chip is only selected while phase 2 is high.

Top module: `xbank_ctl`

## Requirements
- R1: After reset the control register reads back `8'hFF`. The block is in compatible mode, the OS ROM is enabled, and the BASIC and self-test ROMs are disabled.
- R2: The register is loaded from `cpu_wdata` on a rising `clk` edge only when `phi2`=1, `cpu_rw`=0 and `cpu_addr`=`16'hD301`. When `phi2`=1, `cpu_rw`=1 and the address is `16'hD301`, `reg_rd_oe` is 1 and `reg_rdata` shows the last value loaded. A write to any other address leaves the register unchanged.
- R3: In compatible mode the ROM enables follow the register: `os_rom_en` = bit 0, `basic_en` = NOT bit 1, and `selftest_en` = (NOT bit 7) AND bit 0.
- R4: In compatible mode an access to `$4000-$7FFF` selects bank 4 + {bit 3, bit 2} when bit 4 is 0, and bank 1 when bit 4 is 1. Bit 5 has no effect on the mapping.
- R5: In extended mode (bit 6 = 0) an access to `$4000-$7FFF` selects bank {bit 7, bit 5, bit 4, bit 3, bit 2, bit 1, bit 0}, with bit 7 as the most significant bit.
- R6: A write with bit 6 = 0 leaves all three ROM enables unchanged. A write with bit 6 = 1 loads them from bits 0, 1 and 7 of the written value. To change BASIC while in extended mode, software must set bit 6, write bit 1, and then clear bit 6.
- R7: Outside `$4000-$7FFF` a RAM access always uses bank `cpu_addr[15:14]` (banks 0-3), in either mode.
- R8: Neither SRAM chip is selected for `$D000-$D7FF`. Neither is selected for the OS ROM ranges `$C000-$CFFF` and `$D800-$FFFF` while the OS ROM is enabled. Neither is selected for `$A000-$BFFF` while BASIC is enabled, or for `$5000-$57FF` while self-test is enabled.
- R9: Bank bit 6 chooses the chip: 0 selects chip 0, 1 selects chip 1. `sram_ahi` carries bank bits 5..0. Chip 0 is selected with `mem0_ce_n`=0 and `mem0_ce2`=1, and chip 1 with `mem1_ce_n`=0 and `mem1_ce2`=1. The wiring always satisfies `mem0_ce_n`=`mem1_ce2` and `mem0_ce2`=`mem1_ce_n`. Both lines are 0 when nothing is selected, and nothing is selected while `phi2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Phase-2 clock level; qualifies register access and chip enables |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| reg_rdata | output | 8 | Current control register value |
| reg_rd_oe | output | 1 | High while the CPU reads the control register |
| sram_ahi | output | 6 | SRAM address bits 19..14 (bank bits 5..0) |
| mem0_ce_n | output | 1 | Chip 0 active-low enable (same net as mem1_ce2) |
| mem0_ce2 | output | 1 | Chip 0 active-high enable (same net as mem1_ce_n) |
| mem1_ce_n | output | 1 | Chip 1 active-low enable |
| mem1_ce2 | output | 1 | Chip 1 active-high enable |
| os_rom_en | output | 1 | OS ROM enabled |
| basic_en | output | 1 | BASIC ROM enabled |
| selftest_en | output | 1 | Self-test ROM enabled |

## Verification
On every cycle the assertions check three things. The register comes out of reset as all ones and moves only on a decoded write. The ROM-control state survives any write that clears the mode bit. A RAM access below or above the window lands in chip 0 at banks 0-3, exactly one chip is enabled during a phase-2 RAM access, and no chip is enabled otherwise.

The bank arithmetic of both modes, the ROM overlay priorities and the set-write-clear sequence for BASIC are shown only by the bench's scenarios. These scenarios include random register values and addresses and the extreme banks 0 and 127, and they compare the results against a separate model.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

   // Control register field positions (behavioural: software relies on them)
   localparam int unsigned OS_BIT    = 0;
   localparam int unsigned BASIC_BIT = 1;
   localparam int unsigned XSEL_LO   = 2;
   localparam int unsigned XEN_BIT   = 4;
   localparam int unsigned MODE_BIT  = 6;
   localparam int unsigned ST_BIT    = 7;

   // ROM-control functions held across extended mode
   typedef struct packed {
      logic st_n;
      logic basic_n;
      logic os_on;
   } romctl_t;

   localparam romctl_t ROMCTL_RESET = '{st_n: 1'b1, basic_n: 1'b1, os_on: 1'b1};

endpackage

// File: rtl/xbank_reg.sv
module xbank_reg
   import xbank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter logic [15:0] REG_ADDR = 16'hD301
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rw,
   output logic [DATA_W-1:0] ctl_q,
   output romctl_t           rom_hold,
   output logic              rd_oe
);

   logic addr_hit;
   logic wr_hit;

   assign addr_hit = (cpu_addr == ADDR_W'(REG_ADDR));
   assign wr_hit   = phi2 & ~cpu_rw & addr_hit;
   assign rd_oe    = phi2 &  cpu_rw & addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '1;
         rom_hold <= ROMCTL_RESET;
      end else if (wr_hit) begin
         ctl_q <= cpu_wdata;
         if (cpu_wdata[MODE_BIT]) begin
            rom_hold <= '{st_n:    cpu_wdata[ST_BIT],
                          basic_n: cpu_wdata[BASIC_BIT],
                          os_on:   cpu_wdata[OS_BIT]};
         end
      end
   end

   assert_reset_value_R1: assert property (@(posedge clk)
      !rst_n |=> (ctl_q == '1 && rom_hold == ROMCTL_RESET));

   assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(ctl_q));

   assert_rom_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && cpu_wdata[MODE_BIT]) |=> $stable(rom_hold));

endmodule

// File: rtl/xbank_map.sv
module xbank_map
   import xbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BANK_W = 7
)(
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] ctl_q,
   input  romctl_t           rom_hold,
   output logic [BANK_W-1:0] bank,
   output logic              ram_hit,
   output logic              os_en,
   output logic              basic_on,
   output logic              st_en
);

   localparam int unsigned SEG_HI = ADDR_W - 1;
   localparam int unsigned SEG_LO = ADDR_W - 2;

   logic [BANK_W-1:0] ext_bank;
   logic [BANK_W-1:0] xe_bank;
   logic [BANK_W-1:0] base_bank;
   logic              in_window;
   logic              ext_mode;
   logic              io_hit, os_hit, basic_hit, st_hit;

   // Extended bank: every register bit except the mode bit, order kept
   for (genvar i = 0; i < DATA_W; i++) begin : g_ext
      if (i < MODE_BIT) begin : g_lo
         assign ext_bank[i] = ctl_q[i];
      end else if (i > MODE_BIT) begin : g_hi
         assign ext_bank[i-1] = ctl_q[i];
      end
   end

   assign ext_mode  = ~ctl_q[MODE_BIT];
   assign in_window = (cpu_addr[SEG_HI:SEG_LO] == 2'b01);
   assign base_bank = BANK_W'(cpu_addr[SEG_HI:SEG_LO]);
   assign xe_bank   = ctl_q[XEN_BIT] ? BANK_W'(1)
                                     : BANK_W'({1'b1, ctl_q[XSEL_LO+1:XSEL_LO]});

   always_comb begin
      if (!in_window)    bank = base_bank;
      else if (ext_mode) bank = ext_bank;
      else               bank = xe_bank;
   end

   // ROM enables come only from the held copy
   assign os_en    = rom_hold.os_on;
   assign basic_on = ~rom_hold.basic_n;
   assign st_en    = ~rom_hold.st_n & rom_hold.os_on;

   assign io_hit    = (cpu_addr[15:11] == 5'b11010);
   assign os_hit    = os_en & ((cpu_addr[15:12] == 4'hC) | (cpu_addr[15:11] >= 5'b11011));
   assign basic_hit = basic_on & (cpu_addr[15:13] == 3'b101);
   assign st_hit    = st_en & (cpu_addr[15:11] == 5'b01010);
   assign ram_hit   = ~(io_hit | os_hit | basic_hit | st_hit);

endmodule

// File: rtl/xbank_csel.sv
module xbank_csel #(
   parameter int unsigned BANK_W  = 7,
   parameter bit          GATE_CE = 1'b1
)(
   input  logic              phi2,
   input  logic [BANK_W-1:0] bank,
   input  logic              ram_hit,
   output logic [BANK_W-2:0] sram_ahi,
   output logic              mem0_ce_n,
   output logic              mem0_ce2,
   output logic              mem1_ce_n,
   output logic              mem1_ce2
);

   localparam int unsigned CHIP_AW = BANK_W - 1;

   logic qual;
   logic line_hi;
   logic line_lo;

   if (GATE_CE) begin : g_gate
      assign qual = phi2;
   end else begin : g_level
      assign qual = 1'b1;
   end

   assign line_hi  = qual & ram_hit &  bank[CHIP_AW];
   assign line_lo  = qual & ram_hit & ~bank[CHIP_AW];
   assign sram_ahi = bank[CHIP_AW-1:0];

   // Cross wiring: each line is one chip's low enable and the other's high enable
   assign mem0_ce_n = line_hi;
   assign mem1_ce2  = line_hi;
   assign mem0_ce2  = line_lo;
   assign mem1_ce_n = line_lo;

endmodule

// File: rtl/xbank_ctl.sv
module xbank_ctl
   import xbank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BANK_W   = 7,
   parameter logic [15:0] REG_ADDR = 16'hD301,
   parameter bit          GATE_CE  = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rw,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rd_oe,
   output logic [BANK_W-2:0] sram_ahi,
   output logic              mem0_ce_n,
   output logic              mem0_ce2,
   output logic              mem1_ce_n,
   output logic              mem1_ce2,
   output logic              os_rom_en,
   output logic              basic_en,
   output logic              selftest_en
);

   localparam int unsigned CHIP_AW = BANK_W - 1;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("xbank_ctl: ADDR_W must be 16");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("xbank_ctl: DATA_W must be 8");
   end
   if (BANK_W != DATA_W - 1) begin : g_bad_bank
      $error("xbank_ctl: BANK_W must be DATA_W-1");
   end

   logic [DATA_W-1:0] ctl_q;
   romctl_t           rom_hold;
   logic [BANK_W-1:0] bank;
   logic              ram_hit;

   xbank_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rw(cpu_rw), .ctl_q(ctl_q),
      .rom_hold(rom_hold), .rd_oe(reg_rd_oe));

   xbank_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_map (
      .cpu_addr(cpu_addr), .ctl_q(ctl_q), .rom_hold(rom_hold), .bank(bank),
      .ram_hit(ram_hit), .os_en(os_rom_en), .basic_on(basic_en), .st_en(selftest_en));

   xbank_csel #(.BANK_W(BANK_W), .GATE_CE(GATE_CE)) u_csel (
      .phi2(phi2), .bank(bank), .ram_hit(ram_hit), .sram_ahi(sram_ahi),
      .mem0_ce_n(mem0_ce_n), .mem0_ce2(mem0_ce2),
      .mem1_ce_n(mem1_ce_n), .mem1_ce2(mem1_ce2));

   assign reg_rdata = ctl_q;

   logic sel0, sel1;
   assign sel0 = ~mem0_ce_n & mem0_ce2;
   assign sel1 = ~mem1_ce_n & mem1_ce2;

   assert_one_chip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2 && ram_hit) |-> $onehot({sel0, sel1}));

   assert_no_chip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_hit || (GATE_CE && !phi2)) |-> !(sel0 || sel1));

   assert_base_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] != 2'b01 && (sel0 || sel1))
         |-> (sel0 && sram_ahi[CHIP_AW-1:2] == '0));

endmodule

// File: tb/test_xbank_ctl.sv
`timescale 1ns/1ps
module test_xbank_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_wdata = 8'h00;
   logic        cpu_rw = 1'b1;
   logic [7:0]  reg_rdata;
   logic        reg_rd_oe;
   logic [5:0]  sram_ahi;
   logic        mem0_ce_n, mem0_ce2, mem1_ce_n, mem1_ce2;
   logic        os_rom_en, basic_en, selftest_en;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // model state
   logic [7:0] m_pb    = 8'hFF;
   logic       m_os    = 1'b1;
   logic       m_bas_n = 1'b1;
   logic       m_st_n  = 1'b1;

   always #4 clk = ~clk;

   xbank_ctl i_xbank_ctl (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rw(cpu_rw), .reg_rdata(reg_rdata),
      .reg_rd_oe(reg_rd_oe), .sram_ahi(sram_ahi), .mem0_ce_n(mem0_ce_n),
      .mem0_ce2(mem0_ce2), .mem1_ce_n(mem1_ce_n), .mem1_ce2(mem1_ce2),
      .os_rom_en(os_rom_en), .basic_en(basic_en), .selftest_en(selftest_en));

   function automatic logic [6:0] exp_bank(input logic [15:0] a);
      if (a[15:14] != 2'b01) return {5'b0, a[15:14]};           // R7
      if (!m_pb[6])          return {m_pb[7], m_pb[5:0]};        // R5
      if (!m_pb[4])          return 7'd4 + {5'b0, m_pb[3:2]};    // R4
      return 7'd1;
   endfunction

   // {os, basic, selftest, mem0_ce_n, mem0_ce2, mem1_ce_n, mem1_ce2, ahi}
   function automatic logic [12:0] exp_out(input logic [15:0] a, input logic p2);
      logic os, bas, st, ram;
      logic [6:0] b;
      os  = m_os;
      bas = !m_bas_n;
      st  = !m_st_n && m_os;
      ram = !(a >= 16'hD000 && a <= 16'hD7FF);
      if (os  && ((a >= 16'hC000 && a <= 16'hCFFF) || a >= 16'hD800)) ram = 1'b0;
      if (bas && a >= 16'hA000 && a <= 16'hBFFF) ram = 1'b0;
      if (st  && a >= 16'h5000 && a <= 16'h57FF) ram = 1'b0;
      b = exp_bank(a);
      if (!(ram && p2))  return {os, bas, st, 4'b0000, 6'd0};
      if (b[6])          return {os, bas, st, 4'b1001, b[5:0]};
      return {os, bas, st, 4'b0110, b[5:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic probe(input logic [15:0] a, input logic p2, input string req);
      logic [12:0] act;
      @(negedge clk);
      cpu_addr = a; cpu_rw = 1'b1; phi2 = p2;
      #2;
      act = {os_rom_en, basic_en, selftest_en, mem0_ce_n, mem0_ce2, mem1_ce_n, mem1_ce2,
             sram_ahi};
      if (!(mem0_ce_n || mem0_ce2 || mem1_ce_n || mem1_ce2)) act[5:0] = 6'd0;
      check($sformatf("%s addr=%h", req, a), {19'd0, act}, {19'd0, exp_out(a, p2)});
   endtask

   task automatic readback(input string req);
      @(negedge clk);
      cpu_addr = 16'hD301; cpu_rw = 1'b1; phi2 = 1'b1;
      #2;
      check(req, {23'd0, reg_rd_oe, reg_rdata}, {23'd0, 1'b1, m_pb});
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; phi2 = 1'b1;
      @(negedge clk);
      cpu_rw = 1'b1; cpu_addr = 16'h0000;
      if (a == 16'hD301) begin
         m_pb = d;
         if (d[6]) begin
            m_os = d[0]; m_bas_n = d[1]; m_st_n = d[7];
         end
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      readback("R1 reset readback");
      probe(16'hE000, 1'b1, "R1 OS on");
      probe(16'hA000, 1'b1, "R1 BASIC off");
      probe(16'h5000, 1'b1, "R1 selftest off");

      // R2: other address and reads do not load
      wr(16'hD300, 8'h00);
      readback("R2 other addr ignored");
      wr(16'hD301, 8'h5A);
      readback("R2 write load");

      // R3: compatible ROM enables
      wr(16'hD301, 8'h7C);
      probe(16'hC000, 1'b1, "R3 OS off");
      probe(16'hB000, 1'b1, "R3 BASIC on");
      probe(16'h5400, 1'b1, "R3 selftest on but OS off");
      wr(16'hD301, 8'h7D);
      probe(16'h5400, 1'b1, "R3 selftest on");

      // R4: compatible window, bit 5 no effect
      wr(16'hD301, 8'h4D);
      probe(16'h4000, 1'b1, "R4 bank 7");
      wr(16'hD301, 8'h6D);
      probe(16'h4000, 1'b1, "R4 bit5 ignored");
      wr(16'hD301, 8'h5D);
      probe(16'h7FFF, 1'b1, "R4 bit4 high base");

      // R5: extended extremes
      wr(16'hD301, 8'hBF);
      probe(16'h6000, 1'b1, "R5 bank 127");
      wr(16'hD301, 8'h00);
      probe(16'h4100, 1'b1, "R5 bank 0");

      // R6: freeze sequence (OS on, BASIC off, selftest off currently)
      wr(16'hD301, 8'hFF);
      wr(16'hD301, 8'h3C);
      probe(16'hA000, 1'b1, "R6 BASIC held off");
      probe(16'hC000, 1'b1, "R6 OS held on");
      wr(16'hD301, 8'hFD);
      wr(16'hD301, 8'hBD);
      probe(16'hA000, 1'b1, "R6 BASIC on after set-write-clear");

      // R7/R8/R9 directed
      probe(16'h0123, 1'b1, "R7 base bank 0 in ext mode");
      probe(16'hD400, 1'b1, "R8 IO no select");
      probe(16'h4000, 1'b0, "R9 phi2 low no select");

      // random mix
      for (int i = 0; i < 800; i++) begin
         int op;
         logic [15:0] a;
         op = $urandom_range(0, 7);
         a  = 16'($urandom);
         if (op < 3) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) d[6] = 1'b0;
            wr(16'hD301, d);
            readback("R2 random readback");
         end else if (op == 3) begin
            if (a == 16'hD301) a = 16'hD302;
            wr(a, 8'($urandom));
            readback("R2 random stray write");
         end else if (op == 4) begin
            probe({2'b01, a[13:0]}, 1'b1, "R5 random window");
         end else begin
            probe(a, 1'($urandom_range(0, 4) != 0), "R9 random access");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule